// File: doc/BRIEF.md
# Flow-Control Frame Scheduler

This block sits in an Ethernet MAC transmit path and decides when a flow-control (pause) frame must be slotted in between ordinary frames. It watches two sources. The first is a software-set request bit that asks for one pause frame. The second is a threshold flag from the receive FIFO. When the flag goes high the block schedules a frame that tells the link partner to stop sending (XOFF, carrying the programmed quanta). When the flag goes low it schedules a frame that lets the partner resume (XON, carrying a quanta of zero).

No insertion ever interrupts a frame that is already on the wire. The block launches a request to the frame builder only while the transmitter reports that it is idle. It holds that request until the builder accepts it. Once the software-requested frame is accepted, the block pulses a done strobe that the register file uses to clear the request bit. It can also raise a one-cycle interrupt.

Top module: `pause_sched`

## Requirements
- R1: While reset is held, and on the first cycle after it, `pause_req_o`, `host_done_o` and `irq_o` are low.
- R2: A high `host_req_i` produces exactly one pause frame. That frame has `pause_xoff_o`=1 and `pause_quanta_o` equal to `quanta_cfg_i`. No further frame is launched while `host_req_i` stays high after its done pulse.
- R3: A request is never launched while `tx_busy_i` is high. A pending request launches on the cycle after `tx_busy_i` is seen low.
- R4: `host_done_o` is a one-cycle pulse in the cycle after the clock edge at which `pause_ack_i` accepts a host-sourced frame. It stays low for FIFO-sourced frames.
- R5: `irq_o` pulses together with `host_done_o` only when `irq_en_i` is 1. Otherwise it stays low.
- R6: A rising edge of `fifo_thr_i` schedules a frame with `pause_xoff_o`=1 and `pause_quanta_o`=`quanta_cfg_i`.
- R7: A falling edge of `fifo_thr_i` schedules a frame with `pause_xoff_o`=0 and `pause_quanta_o`=0.
- R8: If the threshold flag toggles back before its pending frame launches, the pending frame is replaced by the newer type. Only one frame is sent.
- R9: When a host request and a FIFO-triggered frame are both pending, the FIFO frame is launched first. The host frame follows at the next idle boundary.
- R10: While `pause_req_o` is high and `pause_ack_i` is low, the request, its type and its quanta stay unchanged.
- R11: A flag edge of the opposite type arriving while a FIFO frame request is outstanding is not lost. It is launched after the current request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req_i | input | 1 | Software pause request bit (level) |
| fifo_thr_i | input | 1 | Receive FIFO threshold flag |
| tx_busy_i | input | 1 | High while a frame is being transmitted |
| quanta_cfg_i | input | 16 | Programmed pause quanta |
| irq_en_i | input | 1 | Interrupt enable |
| pause_ack_i | input | 1 | Frame builder accepts the request |
| pause_req_o | output | 1 | Pause frame request |
| pause_xoff_o | output | 1 | 1 = XOFF or host frame, 0 = XON |
| pause_quanta_o | output | 16 | Quanta to place in the frame |
| host_done_o | output | 1 | Clears the software request bit |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench keeps the software request bit high after its done pulse. A design without a served guard would send a second frame in that window. It toggles the threshold flag during a busy transmission: a queueing design would send two frames there, where only the newer XON is expected. It holds both sources pending at once to catch an arbiter that favours the host. It also flips the flag while a FIFO request waits for acceptance. A design that cleared the pending flag on acceptance would lose the XON and leave the link partner paused for good.

// File: rtl/pause_pkg.sv
// Shared types for the flow-control frame scheduler.
package pause_pkg;
    typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_FIFO = 2'd1, SRC_HOST = 2'd2} src_e;
    typedef enum logic {KIND_XON = 1'b0, KIND_XOFF = 1'b1} kind_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_REQ = 1'b1} st_e;
endpackage

// File: rtl/pause_fifo_track.sv
// Tracks edges of the receive FIFO threshold flag and keeps at most one
// pending automatic frame, whose type follows the most recent edge.
// Assumes grant_i is a single-cycle strobe naming the type that was sent.
module pause_fifo_track
    import pause_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flag_i,
    input  logic  grant_i,
    input  kind_e grant_kind_i,
    output logic  pend_o,
    output kind_e kind_o
);
    logic flag_q;
    logic rise, fall;

    // Edge decode against the registered flag.
    always_comb begin
        rise = flag_i & ~flag_q;
        fall = ~flag_i & flag_q;
    end

    // Pending slot: newest edge overwrites, grant clears only a matching type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_o <= 1'b0;
            kind_o <= KIND_XON;
        end else begin
            flag_q <= flag_i;
            if (rise) begin
                pend_o <= 1'b1;
                kind_o <= KIND_XOFF;
            end else if (fall) begin
                pend_o <= 1'b1;
                kind_o <= KIND_XON;
            end else if (grant_i && (kind_o == grant_kind_i)) begin
                pend_o <= 1'b0;
            end
        end
    end

    a_r6_rise_xoff: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i && !flag_q) |=> (pend_o && kind_o == KIND_XOFF));
    a_r7_fall_xon: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_i && flag_q) |=> (pend_o && kind_o == KIND_XON));
    a_r11_keep_newer: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && pend_o && kind_o != grant_kind_i) |=> pend_o);
endmodule

// File: rtl/pause_host_track.sv
// Turns the level software request bit into a single pending request.
// Assumes the bit stays high until some cycle after the done strobe; a
// served flag blocks a second frame for as long as the bit lingers.
module pause_host_track (
    input  logic clk,
    input  logic rst_n,
    input  logic host_i,
    input  logic grant_i,
    output logic pend_o
);
    logic served_q;

    // Pending while requested and not yet served.
    always_comb pend_o = host_i & ~served_q;

    // Served flag: set on grant, cleared once software drops the bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (!host_i)  served_q <= 1'b0;
        else if (grant_i)  served_q <= 1'b1;
    end

    a_r2_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> !pend_o);
endmodule

// File: rtl/pause_issue.sv
// Arbitrates between pending sources at frame boundaries and holds one
// request toward the frame builder until it is accepted. FIFO frames win
// over host frames. Assumes the builder raises tx_busy_i from the cycle
// after acceptance until its frame is done.
module pause_issue
    import pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          fifo_pend_i,
    input  kind_e         fifo_kind_i,
    input  logic          host_pend_i,
    input  logic [QW-1:0] quanta_cfg_i,
    input  logic          irq_en_i,
    input  logic          ack_i,
    output logic          req_o,
    output logic          xoff_o,
    output logic [QW-1:0] quanta_o,
    output logic          fifo_grant_o,
    output logic          host_grant_o,
    output kind_e         grant_kind_o,
    output logic          done_o,
    output logic          irq_o
);
    st_e   state_q;
    src_e  src_q;
    kind_e kind_q;
    logic  launch;
    logic  accept;

    // Launch decision and acceptance strobe.
    always_comb begin
        launch       = (state_q == ST_IDLE) && !busy_i && (fifo_pend_i || host_pend_i);
        accept       = (state_q == ST_REQ) && ack_i;
        fifo_grant_o = accept && (src_q == SRC_FIFO);
        host_grant_o = accept && (src_q == SRC_HOST);
        grant_kind_o = kind_q;
        req_o        = (state_q == ST_REQ);
        xoff_o       = (kind_q == KIND_XOFF);
    end

    // Request state, latched source, type and quanta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            src_q    <= SRC_NONE;
            kind_q   <= KIND_XON;
            quanta_o <= '0;
        end else if (launch) begin
            state_q <= ST_REQ;
            if (fifo_pend_i) begin
                src_q    <= SRC_FIFO;
                kind_q   <= fifo_kind_i;
                quanta_o <= (fifo_kind_i == KIND_XOFF) ? quanta_cfg_i : '0;
            end else begin
                src_q    <= SRC_HOST;
                kind_q   <= KIND_XOFF;
                quanta_o <= quanta_cfg_i;
            end
        end else if (accept) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_NONE;
        end
    end

    // Done and interrupt strobes, one cycle after host acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            done_o <= host_grant_o;
            irq_o  <= host_grant_o && irq_en_i;
        end
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i) |=> (req_o && $stable(xoff_o) && $stable(quanta_o)));
    a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(!busy_i));
    a_r7_xon_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !xoff_o) |-> (quanta_o == '0));
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);
    a_r9_fifo_first: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && fifo_pend_i) |=> (src_q == SRC_FIFO));
endmodule

// File: rtl/pause_sched.sv
// Top of the flow-control frame scheduler: edge tracker for the FIFO
// threshold, level tracker for the software request, and the issuer that
// drives the frame builder handshake at frame boundaries.
module pause_sched
    import pause_pkg::*;
#(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req_i,
    input  logic          fifo_thr_i,
    input  logic          tx_busy_i,
    input  logic [QW-1:0] quanta_cfg_i,
    input  logic          irq_en_i,
    input  logic          pause_ack_i,
    output logic          pause_req_o,
    output logic          pause_xoff_o,
    output logic [QW-1:0] pause_quanta_o,
    output logic          host_done_o,
    output logic          irq_o
);
    logic  fifo_pend, host_pend;
    kind_e fifo_kind, grant_kind;
    logic  fifo_grant, host_grant;

    pause_fifo_track u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .flag_i       (fifo_thr_i),
        .grant_i      (fifo_grant),
        .grant_kind_i (grant_kind),
        .pend_o       (fifo_pend),
        .kind_o       (fifo_kind)
    );

    pause_host_track u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_i  (host_req_i),
        .grant_i (host_grant),
        .pend_o  (host_pend)
    );

    pause_issue #(.QW(QW)) u_issue (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (tx_busy_i),
        .fifo_pend_i  (fifo_pend),
        .fifo_kind_i  (fifo_kind),
        .host_pend_i  (host_pend),
        .quanta_cfg_i (quanta_cfg_i),
        .irq_en_i     (irq_en_i),
        .ack_i        (pause_ack_i),
        .req_o        (pause_req_o),
        .xoff_o       (pause_xoff_o),
        .quanta_o     (pause_quanta_o),
        .fifo_grant_o (fifo_grant),
        .host_grant_o (host_grant),
        .grant_kind_o (grant_kind),
        .done_o       (host_done_o),
        .irq_o        (irq_o)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pause_req_o && !host_done_o && !irq_o));
endmodule

// File: tb/pause_sched_tb.sv
// Directed bench for the flow-control frame scheduler.
module pause_sched_tb_top;
    localparam int QW = 16;
    localparam logic [QW-1:0] QCFG = 16'h1234;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, fifo_thr = 1'b0, tx_busy = 1'b0;
    logic [QW-1:0] quanta_cfg = QCFG;
    logic          irq_en = 1'b0, ack = 1'b0;
    logic          req, xoff, done, irq;
    logic [QW-1:0] quanta;
    int            n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    pause_sched #(.QW(QW)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req_i(host_req), .fifo_thr_i(fifo_thr),
        .tx_busy_i(tx_busy), .quanta_cfg_i(quanta_cfg), .irq_en_i(irq_en),
        .pause_ack_i(ack), .pause_req_o(req), .pause_xoff_o(xoff),
        .pause_quanta_o(quanta), .host_done_o(done), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Wait for a request, check it, accept it, model the transmitted frame.
    task automatic serve(input string tag, input logic exp_xoff, input logic [QW-1:0] exp_q,
                         input logic exp_host);
        int waited = 0;
        while (!req && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " req seen"}, {31'd0, req}, 32'd1);
        check({tag, " type"}, {31'd0, xoff}, {31'd0, exp_xoff});
        check({tag, " quanta"}, {16'd0, quanta}, {16'd0, exp_q});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        tx_busy = 1'b1;
        check({tag, " R4 done"}, {31'd0, done}, {31'd0, exp_host});
        check({tag, " R5 irq"}, {31'd0, irq}, {31'd0, exp_host & irq_en});
        @(negedge clk);
        check({tag, " R4 done one cycle"}, {31'd0, done}, 32'd0);
        repeat (2) @(negedge clk);
        tx_busy = 1'b0;
    endtask

    task automatic expect_idle(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(tag, {31'd0, req}, 32'd0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 req in reset", {31'd0, req}, 32'd0);
        check("R1 done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req after reset", {31'd0, req}, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_host_once;
        irq_en = 1'b1;
        host_req = 1'b1;
        serve("R2 host frame", 1'b1, QCFG, 1'b1);
        expect_idle("R2 no repeat while bit high", 4);
        host_req = 1'b0;
        expect_idle("R2 idle after clear", 2);
    endtask

    task automatic t_boundary;
        irq_en = 1'b0;
        tx_busy = 1'b1;
        host_req = 1'b1;
        expect_idle("R3 held during busy", 5);
        tx_busy = 1'b0;
        @(negedge clk);
        check("R3 launch after idle", {31'd0, req}, 32'd1);
        serve("R3 R5 host no irq", 1'b1, QCFG, 1'b1);
        host_req = 1'b0;
        expect_idle("R3 idle", 2);
    endtask

    task automatic t_fifo_edges;
        fifo_thr = 1'b1;
        serve("R6 xoff on rise", 1'b1, QCFG, 1'b0);
        expect_idle("R6 single xoff", 3);
        fifo_thr = 1'b0;
        serve("R7 xon on fall", 1'b0, 16'h0000, 1'b0);
        expect_idle("R7 single xon", 3);
    endtask

    task automatic t_replace;
        tx_busy = 1'b1;
        fifo_thr = 1'b1;
        repeat (2) @(negedge clk);
        fifo_thr = 1'b0;
        repeat (2) @(negedge clk);
        tx_busy = 1'b0;
        serve("R8 replaced by xon", 1'b0, 16'h0000, 1'b0);
        expect_idle("R8 only one frame", 5);
    endtask

    task automatic t_priority;
        tx_busy = 1'b1;
        host_req = 1'b1;
        fifo_thr = 1'b1;
        repeat (2) @(negedge clk);
        tx_busy = 1'b0;
        serve("R9 fifo first", 1'b1, QCFG, 1'b0);
        serve("R9 host next", 1'b1, QCFG, 1'b1);
        host_req = 1'b0;
        fifo_thr = 1'b0;
        serve("R9 cleanup xon", 1'b0, 16'h0000, 1'b0);
        expect_idle("R9 idle", 3);
    endtask

    task automatic t_hold_and_flip;
        quanta_cfg = 16'hBEEF;
        fifo_thr = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 req up", {31'd0, req}, 32'd1);
        fifo_thr = 1'b0;
        quanta_cfg = 16'h0F0F;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 req held", {31'd0, req}, 32'd1);
            check("R10 type held", {31'd0, xoff}, 32'd1);
            check("R10 quanta held", {16'd0, quanta}, 32'h0000BEEF);
        end
        serve("R11 outstanding xoff", 1'b1, 16'hBEEF, 1'b0);
        serve("R11 newer xon kept", 1'b0, 16'h0000, 1'b0);
        expect_idle("R11 idle", 3);
    endtask

    initial begin
        t_reset();
        t_host_once();
        t_boundary();
        t_fifo_edges();
        t_replace();
        t_priority();
        t_hold_and_flip();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule